// File: doc/BRIEF.md
# Interrupt Aggregation and Pin Controller

This block gathers single-cycle event strobes from a USB protocol core and from a DMA engine into two sticky status registers and reduces them to one interrupt pin. Each status register has its own enable mask. A global enable then gates the combined request before it reaches the pin. Software reaches the block through a small synchronous register port. It reads status, clears bits by writing ones, and sets the masks, the global enable, the pin polarity and the signalling mode.

In level mode the pin holds its asserted state for as long as any enabled status bit is pending and the global enable is set. In pulse mode the pin gives one pulse of a fixed, parameterised number of clock cycles each time the combined request goes from idle to active. A group of USB event bits belongs to individual data pipes. A per-pipe gate register decides whether events on those bits are recorded at all.

Top module: `irq_aggregator`

## Requirements
- R1: An event strobe on `usb_ev_i[k]` or `dma_ev_i[k]` sets status bit k on the next clock edge, whatever the enables and the global enable hold. The USB status reads at address 0 and the DMA status reads at address 2.
- R2: A pending status bit drives the pin only when its bit in the matching enable register is 1. The USB enable is at address 1 and the DMA enable is at address 3.
- R3: The configuration register at address 4 holds bit 0 global enable, bit 1 polarity (1 = active high) and bit 2 mode (1 = pulse). If the global enable is written to 1 while an enabled bit is pending, the pin asserts on the edge after the write is stored.
- R4: A write to a status address with every byte strobe set clears each status bit whose write-data bit is 1. An event in the same cycle as the clear of its bit leaves that bit set.
- R5: Writing the global enable to 0 drives the pin inactive on the edge after the write is stored, even while enabled bits remain pending.
- R6: After reset the pin is high (inactive, active-low polarity), the mode is level, the global enable and both enable masks are 0, and the pipe gate register reads all ones.
- R7: A write to a status address with any byte strobe clear leaves that status register unchanged.
- R8: In pulse mode, a 0-to-1 change of the combined request (global enable AND any enabled pending bit) makes the pin assert for exactly PULSE_CYCLES clock cycles.
- R9: In pulse mode, new events that arrive while the combined request is already 1 produce no further pulse.
- R10: The pipe gate register at address 5 has bit p gating USB event bit PIPE_BASE+p (default bits 13 to 15). When the gate bit is 0, events on that bit are not recorded.
- R11: In level mode the pin equals the combined request, inverted when the polarity bit is 0, one edge after the request changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_ev_i | input | USB_W | USB event strobes, one bit per event |
| dma_ev_i | input | DMA_W | DMA event strobes, one bit per event |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| wstrb_i | input | DATA_W/8 | Byte strobes for the write |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| int_o | output | 1 | Interrupt pin |

## Verification
An event or register write applied before edge E updates the status and configuration registers at E. Readback is therefore valid right after E, and the pin, which is registered, changes at edge E+1. The bench drives every stimulus on a falling edge and removes it on the next falling edge. It samples the pin one falling edge later, and it samples readback half a cycle after the address is set. Pulse widths are measured by counting asserted samples over a fixed window of falling edges that starts when the event is removed, so the count equals the pulse length in cycles.

// File: rtl/irq_agg_pkg.sv
// Shared register addresses and configuration type for the interrupt aggregator.
package irq_agg_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_USB_STAT  = 3'd0,
        A_USB_EN    = 3'd1,
        A_DMA_STAT  = 3'd2,
        A_DMA_EN    = 3'd3,
        A_CFG       = 3'd4,
        A_PIPE_GATE = 3'd5
    } reg_addr_e;

    // Field order places glb_en at bit 0, pol_high at bit 1, pulse_mode at bit 2.
    typedef struct packed {
        logic pulse_mode;
        logic pol_high;
        logic glb_en;
    } irq_cfg_t;
endpackage

// File: rtl/irq_status_bank.sv
// Sticky event status register with write-one-to-clear.
// Assumes event strobes are synchronous to clk. A set wins over a clear in the same cycle.
module irq_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] keep;

    // Bits that survive this cycle's clear.
    always_comb keep = clr_en_i ? (stat_q & ~clr_mask_i) : stat_q;

    // Latch new events on top of the surviving bits.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= keep | ev_i;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/irq_cfg_regs.sv
// Enable masks, pipe gates and pin configuration, written through the register port.
// Assumes each byte of a register is written only when its strobe is set.
module irq_cfg_regs
    import irq_agg_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int USB_W     = 16,
    parameter int DMA_W     = 8,
    parameter int NUM_PIPES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_AW-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [DATA_W/8-1:0]   wstrb_i,
    output irq_cfg_t              cfg_o,
    output logic [USB_W-1:0]      usb_en_o,
    output logic [DMA_W-1:0]      dma_en_o,
    output logic [NUM_PIPES-1:0]  gate_o
);
    irq_cfg_t             cfg_q;
    logic [USB_W-1:0]     usb_en_q;
    logic [DMA_W-1:0]     dma_en_q;
    logic [NUM_PIPES-1:0] gate_q;

    // USB enable mask, byte-strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) usb_en_q <= '0;
        else if (wr_en_i && addr_i == A_USB_EN)
            for (int b = 0; b < USB_W; b++)
                if (wstrb_i[b/8]) usb_en_q[b] <= wdata_i[b];
    end

    // DMA enable mask, byte-strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_en_q <= '0;
        else if (wr_en_i && addr_i == A_DMA_EN)
            for (int b = 0; b < DMA_W; b++)
                if (wstrb_i[b/8]) dma_en_q[b] <= wdata_i[b];
    end

    // Pin configuration; held in byte 0.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else if (wr_en_i && addr_i == A_CFG && wstrb_i[0])
            cfg_q <= irq_cfg_t'(wdata_i[2:0]);
    end

    // Per-pipe event gates; open after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= '1;
        else if (wr_en_i && addr_i == A_PIPE_GATE && wstrb_i[0])
            gate_q <= wdata_i[NUM_PIPES-1:0];
    end

    assign cfg_o    = cfg_q;
    assign usb_en_o = usb_en_q;
    assign dma_en_o = dma_en_q;
    assign gate_o   = gate_q;
endmodule

// File: rtl/irq_pin_driver.sv
// Turns the combined interrupt request into the pin waveform in level or pulse mode.
// Assumes pending_i already includes the global enable. The pin is registered.
module irq_pin_driver
    import irq_agg_pkg::*;
#(
    parameter int PULSE_CYCLES = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  irq_cfg_t cfg_i,
    input  logic     pending_i,
    output logic     int_o
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             assert_d;
    logic             pin_q;

    // Pulse length counter: reload on a rising request, drop to zero when disabled.
    always_comb begin
        if (!cfg_i.glb_en)               cnt_d = '0;
        else if (pending_i && !prev_q)   cnt_d = CNT_W'(PULSE_CYCLES);
        else if (cnt_q != '0)            cnt_d = cnt_q - 1'b1;
        else                             cnt_d = '0;
        assert_d = cfg_i.pulse_mode ? (cnt_d != '0) : pending_i;
    end

    // Edge memory, pulse counter and polarity-adjusted pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
            pin_q  <= 1'b1;
        end else begin
            prev_q <= pending_i;
            cnt_q  <= cnt_d;
            pin_q  <= assert_d ? cfg_i.pol_high : ~cfg_i.pol_high;
        end
    end

    assign int_o = pin_q;
endmodule

// File: rtl/irq_aggregator.sv
// Top: collects USB and DMA events into status registers and drives one interrupt pin.
// Assumes USB_W and DMA_W do not exceed DATA_W and the pipe bits lie inside USB_W.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int USB_W        = 16,
    parameter int DMA_W        = 8,
    parameter int NUM_PIPES    = 3,
    parameter int PIPE_BASE    = 13,
    parameter int PULSE_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [USB_W-1:0]     usb_ev_i,
    input  logic [DMA_W-1:0]     dma_ev_i,
    input  logic                 wr_en_i,
    input  logic [REG_AW-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [DATA_W/8-1:0]  wstrb_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 int_o
);
    irq_cfg_t             cfg_q;
    logic [USB_W-1:0]     usb_en, usb_stat, usb_ev_eff;
    logic [DMA_W-1:0]     dma_en, dma_stat;
    logic [NUM_PIPES-1:0] pipe_gate;
    logic                 full_wr, usb_clr, dma_clr, pending;

    // Pipe-owned event bits pass only while their gate is open.
    for (genvar k = 0; k < USB_W; k++) begin : g_ev_gate
        if (k >= PIPE_BASE && k < PIPE_BASE + NUM_PIPES) begin : g_pipe
            assign usb_ev_eff[k] = usb_ev_i[k] & pipe_gate[k-PIPE_BASE];
        end else begin : g_plain
            assign usb_ev_eff[k] = usb_ev_i[k];
        end
    end

    // Clears require every byte strobe.
    always_comb begin
        full_wr = wr_en_i && (&wstrb_i);
        usb_clr = full_wr && addr_i == A_USB_STAT;
        dma_clr = full_wr && addr_i == A_DMA_STAT;
    end

    irq_cfg_regs #(
        .DATA_W(DATA_W), .USB_W(USB_W), .DMA_W(DMA_W), .NUM_PIPES(NUM_PIPES)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wstrb_i(wstrb_i), .cfg_o(cfg_q),
        .usb_en_o(usb_en), .dma_en_o(dma_en), .gate_o(pipe_gate)
    );

    irq_status_bank #(.W(USB_W)) usb_bank_i (
        .clk(clk), .rst_n(rst_n), .ev_i(usb_ev_eff), .clr_en_i(usb_clr),
        .clr_mask_i(wdata_i[USB_W-1:0]), .stat_o(usb_stat)
    );

    irq_status_bank #(.W(DMA_W)) dma_bank_i (
        .clk(clk), .rst_n(rst_n), .ev_i(dma_ev_i), .clr_en_i(dma_clr),
        .clr_mask_i(wdata_i[DMA_W-1:0]), .stat_o(dma_stat)
    );

    // Combined request: global enable AND any enabled pending bit.
    always_comb pending = cfg_q.glb_en &&
                          ((|(usb_stat & usb_en)) || (|(dma_stat & dma_en)));

    irq_pin_driver #(.PULSE_CYCLES(PULSE_CYCLES)) pin_i (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_q), .pending_i(pending), .int_o(int_o)
    );

    // Read-back multiplexer.
    always_comb begin
        unique case (addr_i)
            A_USB_STAT:  rdata_o = DATA_W'(usb_stat);
            A_USB_EN:    rdata_o = DATA_W'(usb_en);
            A_DMA_STAT:  rdata_o = DATA_W'(dma_stat);
            A_DMA_EN:    rdata_o = DATA_W'(dma_en);
            A_CFG:       rdata_o = DATA_W'(cfg_q);
            A_PIPE_GATE: rdata_o = DATA_W'(pipe_gate);
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Property checker for irq_aggregator, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled while it is low.
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int USB_W  = 16,
    parameter int DMA_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DMA_W-1:0]    dma_ev_i,
    input logic                wr_en_i,
    input logic [REG_AW-1:0]   addr_i,
    input logic [DATA_W-1:0]   wdata_i,
    input logic [DATA_W/8-1:0] wstrb_i,
    input logic                int_o,
    input irq_cfg_t            cfg_q,
    input logic [USB_W-1:0]    usb_ev_eff,
    input logic [USB_W-1:0]    usb_stat,
    input logic [USB_W-1:0]    usb_en,
    input logic [DMA_W-1:0]    dma_stat,
    input logic [DMA_W-1:0]    dma_en
);
    logic gen, pol, pmode, act;

    // Independent view of configuration and combined request.
    always_comb begin
        gen   = cfg_q.glb_en;
        pol   = cfg_q.pol_high;
        pmode = cfg_q.pulse_mode;
        act   = gen && ((|(usb_stat & usb_en)) || (|(dma_stat & dma_en)));
    end

    p_usb_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((usb_stat & $past(usb_ev_eff)) == $past(usb_ev_eff)));

    p_dma_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((dma_stat & $past(dma_ev_i)) == $past(dma_ev_i)));

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_USB_STAT && (&wstrb_i) && usb_ev_eff == '0)
        |=> ((usb_stat & $past(wdata_i[USB_W-1:0])) == '0));

    p_partial_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_USB_STAT && !(&wstrb_i))
        |=> ((usb_stat & $past(usb_stat)) == $past(usb_stat)));

    p_gen_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |=> (int_o == !$past(pol)));

    p_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pmode |=> (int_o == ($past(pol) ? $past(act) : !$past(act))));

    p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode && act && !$past(act)) |=> (int_o == $past(pol)));
endmodule

bind irq_aggregator irq_aggregator_chk #(
    .DATA_W(DATA_W), .USB_W(USB_W), .DMA_W(DMA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .dma_ev_i(dma_ev_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .wstrb_i(wstrb_i), .int_o(int_o),
    .cfg_q(cfg_q), .usb_ev_eff(usb_ev_eff), .usb_stat(usb_stat),
    .usb_en(usb_en), .dma_stat(dma_stat), .dma_en(dma_en)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] usb_ev = '0;
    logic [7:0]  dma_ev = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  wstrb = '0;
    logic [15:0] rdata;
    logic        int_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator #(.PULSE_CYCLES(PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .usb_ev_i(usb_ev), .dma_ev_i(dma_ev),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .wstrb_i(wstrb),
        .rdata_o(rdata), .int_o(int_o)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [15:0] wdata;
        logic [1:0]  strb;
        logic [15:0] uev;
        logic [7:0]  dev;
        logic        exp_int;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 16'h0000, 2'b00, 16'h0000, 8'h00, 1'b1}, // R6 idle pin high
        '{1'b0, 3'd0, 16'h0000, 2'b00, 16'h0001, 8'h00, 1'b1}, // R1 latch while gen off
        '{1'b1, 3'd1, 16'h0001, 2'b11, 16'h0000, 8'h00, 1'b1}, // R2 enable, gen still off
        '{1'b1, 3'd4, 16'h0001, 2'b11, 16'h0000, 8'h00, 1'b0}, // R3 gen on with pending
        '{1'b1, 3'd0, 16'h0001, 2'b01, 16'h0000, 8'h00, 1'b0}, // R7 partial clear ignored
        '{1'b1, 3'd0, 16'hFFFF, 2'b11, 16'h0000, 8'h00, 1'b1}, // R4 full clear
        '{1'b0, 3'd0, 16'h0000, 2'b00, 16'h0000, 8'h04, 1'b1}, // R2 dma masked
        '{1'b1, 3'd3, 16'h0004, 2'b11, 16'h0000, 8'h00, 1'b0}, // R2 dma enabled
        '{1'b1, 3'd4, 16'h0003, 2'b11, 16'h0000, 8'h00, 1'b1}, // R11 active high
        '{1'b1, 3'd2, 16'h0004, 2'b11, 16'h0000, 8'h00, 1'b0}, // R4 dma clear
        '{1'b1, 3'd0, 16'h0001, 2'b11, 16'h0001, 8'h00, 1'b1}, // R4 set wins over clear
        '{1'b1, 3'd4, 16'h0002, 2'b11, 16'h0000, 8'h00, 1'b0}, // R5 gen off deasserts
        '{1'b1, 3'd4, 16'h0003, 2'b11, 16'h0000, 8'h00, 1'b1}, // R3 gen back on
        '{1'b1, 3'd0, 16'hFFFF, 2'b11, 16'h0000, 8'h00, 1'b0}, // R4 clear all
        '{1'b1, 3'd5, 16'h0006, 2'b11, 16'h0000, 8'h00, 1'b0}, // R10 close pipe 0
        '{1'b1, 3'd1, 16'hFFFF, 2'b11, 16'h0000, 8'h00, 1'b0}, // R2 enable all usb
        '{1'b0, 3'd0, 16'h0000, 2'b00, 16'h2000, 8'h00, 1'b0}, // R10 gated pipe event
        '{1'b0, 3'd0, 16'h0000, 2'b00, 16'h4000, 8'h00, 1'b1}, // R10 open pipe event
        '{1'b1, 3'd0, 16'hFFFF, 2'b11, 16'h0000, 8'h00, 1'b0}  // R11 clear, pin idle low
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [2:0] a, input logic [15:0] d,
                         input logic [1:0] s, input logic [15:0] u, input logic [7:0] m);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; wstrb = s; usb_ev = u; dma_ev = m;
        @(negedge clk);
        wr_en = 1'b0; wstrb = '0; usb_ev = '0; dma_ev = '0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, 32'(rdata), 32'(exp));
    endtask

    task automatic count_high(output int n);
        n = 0;
        repeat (10) begin
            @(negedge clk);
            if (int_o) n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R6 reset state
        check("R6 pin", 32'(int_o), 32'd1);
        rst_n = 1'b1;
        read_chk("R6 cfg", 3'd4, 16'h0000);
        read_chk("R6 gate", 3'd5, 16'h0007);
        read_chk("R6 usb_en", 3'd1, 16'h0000);

        // Table walk, level mode
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].strb, VECS[i].uev, VECS[i].dev);
            @(negedge clk);
            check($sformatf("vector %0d pin", i), 32'(int_o), 32'(VECS[i].exp_int));
        end

        // R10 gated event never recorded, open-pipe event was and was cleared
        read_chk("R10 status", 3'd0, 16'h0000);

        // R1 readback with global enable off
        drive(1'b1, 3'd4, 16'h0002, 2'b11, 16'h0000, 8'h00);
        drive(1'b0, 3'd0, 16'h0000, 2'b00, 16'h0000, 8'h20);
        read_chk("R1 dma status", 3'd2, 16'h0020);
        check("R1 pin inactive", 32'(int_o), 32'd0);
        drive(1'b1, 3'd2, 16'h00FF, 2'b11, 16'h0000, 8'h00);

        // R8 pulse mode, active high
        drive(1'b1, 3'd4, 16'h0007, 2'b11, 16'h0000, 8'h00);
        @(negedge clk);
        check("R8 idle before pulse", 32'(int_o), 32'd0);
        drive(1'b0, 3'd0, 16'h0000, 2'b00, 16'h0002, 8'h00);
        count_high(n);
        check("R8 pulse width", 32'(n), 32'(PULSE));
        // R9 no second pulse while request stays high
        drive(1'b0, 3'd0, 16'h0000, 2'b00, 16'h0004, 8'h00);
        count_high(n);
        check("R9 no repeat", 32'(n), 32'd0);
        // R8 pulse again after clear
        drive(1'b1, 3'd0, 16'hFFFF, 2'b11, 16'h0000, 8'h00);
        @(negedge clk);
        drive(1'b0, 3'd0, 16'h0000, 2'b00, 16'h0002, 8'h00);
        count_high(n);
        check("R8 second pulse", 32'(n), 32'(PULSE));

        // R6 reset mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R6 pin after reset", 32'(int_o), 32'd1);
        rst_n = 1'b1;
        read_chk("R6 status cleared", 3'd0, 16'h0000);
        read_chk("R6 cfg cleared", 3'd4, 16'h0000);

        finish_run();
    end
endmodule